// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Tracker

This block watches the stream of retired instructions, one slot per clock, and enforces a simple control-flow rule: whenever a valid indirect jump or indirect call retires, the next valid instruction must be the landing-pad marker, an opcode that does nothing architecturally. If that next instruction is anything else, the block raises a one-cycle control-protection fault pulse for the exception logic downstream.

Each slot carries a valid qualifier and three flags: indirect jump, indirect call and landing pad. Decode, target fetch, exception delivery and direct branches are all handled elsewhere. The tracker has two states, idle and awaiting-pad. An enable input turns enforcement on or off. While enforcement is off, the tracker is held idle and never faults. The parameter `FAULT_STAGE` selects whether the fault pulse comes from a flop (1, the default) or directly from logic (0).

Top module: `ibt_landing_tracker`

## Requirements
- R1: While reset is active, and in the first cycle after it, `pad_pending` and `cp_fault` are low. A reset in the awaiting-pad state returns the tracker to idle.
- R2: In idle with `track_en` high, a slot with `slot_vld` and `slot_ind_jmp` high sets `pad_pending` after that clock edge.
- R3: In idle with `track_en` high, a slot with `slot_vld` and `slot_ind_call` high sets `pad_pending` after that clock edge.
- R4: In awaiting-pad, a valid slot with `slot_pad` high returns the tracker to idle, with no fault.
- R5: In awaiting-pad, a valid slot with `slot_pad` low clears `pad_pending` and, with `FAULT_STAGE`=1, raises `cp_fault` after that same clock edge.
- R6: Slots with `slot_vld` low do not advance the tracker. `pad_pending` holds and no fault is raised, whatever flags those slots carry.
- R7: In awaiting-pad, a valid indirect jump or call counts as a violation. It faults, and the tracker goes to idle rather than re-arming.
- R8: A valid landing-pad slot seen in idle changes nothing.
- R9: With `track_en` low, the tracker goes to idle at the next edge and stays there, and `cp_fault` stays low, whatever the slots carry.
- R10: In idle, a slot with `slot_vld` low is ignored even if its branch flags are set.
- R11: One violation gives a `cp_fault` pulse exactly one cycle long. A non-pad instruction straight after a fault does not fault again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| track_en | input | 1 | Enforcement enable |
| slot_vld | input | 1 | The retired slot holds an instruction |
| slot_ind_jmp | input | 1 | The slot is an indirect jump |
| slot_ind_call | input | 1 | The slot is an indirect call |
| slot_pad | input | 1 | The slot is the landing-pad marker |
| pad_pending | output | 1 | The tracker is awaiting a landing pad |
| cp_fault | output | 1 | Control-protection fault pulse |

## Verification
Two functions can fall in the same cycle: detecting a violation and arming on a new indirect branch. They meet when the slot right after an indirect branch is itself an indirect branch. The bench retires an indirect jump and then, at once, an indirect call. It checks that the fault fires and that `pad_pending` stays low. It then retires a plain instruction and checks that no second fault follows, which shows the call did not re-arm the tracker.

// File: rtl/ibt_pkg.sv
package ibt_pkg;

   typedef enum logic [0:0] {
      TRK_IDLE  = 1'b0,
      TRK_AWAIT = 1'b1
   } trk_state_e;

   typedef struct packed {
      logic vld;
      logic ind_jmp;
      logic ind_call;
      logic pad;
   } slot_t;

   localparam int unsigned SLOT_W = $bits(slot_t);

endpackage

// File: rtl/ibt_slot_classify.sv
module ibt_slot_classify
   import ibt_pkg::*;
(
   input  slot_t slot_i,
   input  logic  en_i,
   output logic  arm_o,
   output logic  land_o,
   output logic  other_o
);

   logic branch;

   always_comb begin
      branch  = slot_i.ind_jmp | slot_i.ind_call;
      arm_o   = en_i & slot_i.vld & branch;
      land_o  = en_i & slot_i.vld & slot_i.pad;
      other_o = en_i & slot_i.vld & ~slot_i.pad;
   end

endmodule

// File: rtl/ibt_track_fsm.sv
module ibt_track_fsm
   import ibt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       arm_i,
   input  logic       land_i,
   input  logic       other_i,
   output trk_state_e state_o,
   output logic       violate_o
);

   trk_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      violate_o = 1'b0;
      if (!en_i) begin
         state_d = TRK_IDLE;
      end else begin
         unique case (state_q)
            TRK_IDLE: begin
               if (arm_i) state_d = TRK_AWAIT;
            end
            TRK_AWAIT: begin
               if (land_i) begin
                  state_d = TRK_IDLE;
               end else if (other_i) begin
                  state_d   = TRK_IDLE;
                  violate_o = 1'b1;
               end
            end
            default: state_d = TRK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TRK_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/ibt_fault_out.sv
module ibt_fault_out #(
   parameter int unsigned FAULT_STAGE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic violate_i,
   output logic fault_o
);

   generate
      if (FAULT_STAGE == 1) begin : g_flop
         logic fault_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fault_q <= 1'b0;
            else        fault_q <= violate_i;
         end
         assign fault_o = fault_q;
      end else begin : g_comb
         assign fault_o = violate_i;
      end
   endgenerate

endmodule

// File: rtl/ibt_landing_tracker.sv
module ibt_landing_tracker
   import ibt_pkg::*;
#(
   parameter int unsigned FAULT_STAGE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic track_en,
   input  logic slot_vld,
   input  logic slot_ind_jmp,
   input  logic slot_ind_call,
   input  logic slot_pad,
   output logic pad_pending,
   output logic cp_fault
);

   generate
      if (FAULT_STAGE > 1) begin : g_bad_stage
         $error("ibt_landing_tracker: FAULT_STAGE must be 0 or 1");
      end
      if (SLOT_W != 4) begin : g_bad_slot
         $error("ibt_landing_tracker: slot record must hold four flags");
      end
   endgenerate

   slot_t      slot;
   logic       arm, land, other, violate;
   trk_state_e state;

   assign slot = '{vld: slot_vld, ind_jmp: slot_ind_jmp,
                   ind_call: slot_ind_call, pad: slot_pad};

   ibt_slot_classify u_classify (
      .slot_i  (slot),
      .en_i    (track_en),
      .arm_o   (arm),
      .land_o  (land),
      .other_o (other)
   );

   ibt_track_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (track_en),
      .arm_i     (arm),
      .land_i    (land),
      .other_i   (other),
      .state_o   (state),
      .violate_o (violate)
   );

   ibt_fault_out #(.FAULT_STAGE(FAULT_STAGE)) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .violate_i (violate),
      .fault_o   (cp_fault)
   );

   assign pad_pending = (state == TRK_AWAIT);

endmodule

// File: rtl/ibt_landing_tracker_chk.sv
module ibt_landing_tracker_chk #(
   parameter int unsigned FAULT_STAGE = 1
) (
   input logic clk,
   input logic rst_n,
   input logic track_en,
   input logic slot_vld,
   input logic slot_ind_jmp,
   input logic slot_ind_call,
   input logic slot_pad,
   input logic pad_pending,
   input logic cp_fault
);

   // R2 R3
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !pad_pending && slot_vld && (slot_ind_jmp || slot_ind_call))
      |=> pad_pending);

   // R4 R5 R7
   leave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && pad_pending && slot_vld) |=> !pad_pending);

   // R6
   hold_idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (track_en && !slot_vld) |=> (pad_pending == $past(pad_pending)));

   // R9
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !track_en |=> !pad_pending);

   generate
      if (FAULT_STAGE == 1) begin : g_flop_chk
         // R5
         fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cp_fault |-> $past(track_en && pad_pending && slot_vld && !slot_pad));

         // R4
         pad_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (track_en && pad_pending && slot_vld && slot_pad) |=> !cp_fault);

         // R11
         single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cp_fault |=> !cp_fault);
      end
   endgenerate

endmodule

bind ibt_landing_tracker ibt_landing_tracker_chk #(.FAULT_STAGE(FAULT_STAGE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .track_en      (track_en),
   .slot_vld      (slot_vld),
   .slot_ind_jmp  (slot_ind_jmp),
   .slot_ind_call (slot_ind_call),
   .slot_pad      (slot_pad),
   .pad_pending   (pad_pending),
   .cp_fault      (cp_fault)
);

// File: tb/test_ibt_landing_tracker.sv
`timescale 1ns/1ps
module test_ibt_landing_tracker;

   logic clk = 1'b0;
   logic rst_n;
   logic track_en, slot_vld, slot_ind_jmp, slot_ind_call, slot_pad;
   logic pad_pending, cp_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ibt_landing_tracker i_ibt_landing_tracker (
      .clk           (clk),
      .rst_n         (rst_n),
      .track_en      (track_en),
      .slot_vld      (slot_vld),
      .slot_ind_jmp  (slot_ind_jmp),
      .slot_ind_call (slot_ind_call),
      .slot_pad      (slot_pad),
      .pad_pending   (pad_pending),
      .cp_fault      (cp_fault)
   );

   // {req[3:0], en, vld, jmp, call, pad, exp_pending, exp_fault}
   localparam int NV = 19;
   localparam logic [10:0] VEC [0:NV-1] = '{
      {4'd8,  5'b11001, 2'b00},   // R8  pad in idle
      {4'd10, 5'b10100, 2'b00},   // R10 invalid jump in idle
      {4'd2,  5'b11100, 2'b10},   // R2  jump arms
      {4'd6,  5'b10000, 2'b10},   // R6  bubble holds
      {4'd6,  5'b10010, 2'b10},   // R6  invalid call holds
      {4'd4,  5'b11001, 2'b00},   // R4  pad lands
      {4'd3,  5'b11010, 2'b10},   // R3  call arms
      {4'd5,  5'b11000, 2'b01},   // R5  plain op faults
      {4'd11, 5'b11000, 2'b00},   // R11 no repeat
      {4'd2,  5'b11100, 2'b10},   // R2  jump arms
      {4'd7,  5'b11010, 2'b01},   // R7  call after jump faults
      {4'd7,  5'b11000, 2'b00},   // R7  not re-armed
      {4'd3,  5'b11010, 2'b10},   // R3  call arms
      {4'd9,  5'b00000, 2'b00},   // R9  disable clears wait
      {4'd9,  5'b01100, 2'b00},   // R9  jump ignored when off
      {4'd9,  5'b01000, 2'b00},   // R9  no fault when off
      {4'd2,  5'b11100, 2'b10},   // R2  jump arms
      {4'd4,  5'b11001, 2'b00},   // R4  pad lands
      {4'd8,  5'b11001, 2'b00}    // R8  pad in idle
   };

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] s);
      {track_en, slot_vld, slot_ind_jmp, slot_ind_call, slot_pad} = s;
   endtask

   initial begin
      rst_n = 1'b0;
      drive(5'b00000);
      repeat (3) @(negedge clk);
      check("R1", pad_pending, 1'b0, "pad_pending in reset");
      check("R1", cp_fault, 1'b0, "cp_fault in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", pad_pending, 1'b0, "pad_pending after reset");
      check("R1", cp_fault, 1'b0, "cp_fault after reset");

      for (int i = 0; i < NV; i++) begin
         string rq;
         drive(VEC[i][6:2]);
         @(negedge clk);
         rq = $sformatf("R%0d", VEC[i][10:7]);
         check(rq, pad_pending, VEC[i][1], $sformatf("pad_pending vec %0d", i));
         check(rq, cp_fault, VEC[i][0], $sformatf("cp_fault vec %0d", i));
      end

      // R1: reset while awaiting a pad
      drive(5'b11100);
      @(negedge clk);
      check("R1", pad_pending, 1'b1, "armed before reset");
      drive(5'b10000);
      rst_n = 1'b0;
      #1;
      check("R1", pad_pending, 1'b0, "pending cleared by reset");
      @(negedge clk);
      rst_n = 1'b1;
      drive(5'b11000);
      @(negedge clk);
      check("R1", cp_fault, 1'b0, "no fault after reset in wait");

      // R6: long gap of bubbles, then a violation
      drive(5'b11010);
      @(negedge clk);
      drive(5'b10000);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R6", pad_pending, 1'b1, "pending over bubbles");
         check("R6", cp_fault, 1'b0, "no fault on bubble");
      end
      drive(5'b11000);
      @(negedge clk);
      check("R5", cp_fault, 1'b1, "fault after gap");
      drive(5'b10000);
      @(negedge clk);
      check("R11", cp_fault, 1'b0, "pulse one cycle");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog run did not finish actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule